// File: doc/BRIEF.md
# Top-Relative Floating-Point Register Stack

This block is the operand register file of a floating-point unit. It keeps eight 80-bit extended-precision words in a circular array and addresses them through a 3-bit top pointer. A command names a slot by its distance `i` from the top, so logical slot ST(i) sits in physical entry `(top + i) mod 8`. Pushing moves the top down by one and writes the new word there. Popping retires the top word and moves the top up by one.

Each cycle, the block presents two operands to an external arithmetic datapath. The left operand is always ST(0). The right operand is either ST(i) or a word supplied from outside. The datapath's result comes back as an opaque 80-bit word. The block writes it to ST(0) in the normal form, or to ST(i) in the reversed form, and can pop in the same cycle. An exchange swaps ST(0) with ST(i), and a store writes ST(i) directly.

Each physical entry carries a valid tag. A push onto an occupied entry sets a sticky overflow flag. Reading an empty entry as an operand sets a sticky underflow flag. A command that faults changes no stored state.

Top module: `fpr_stack`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the stack is reset. `top_o` becomes 0, every bit of `lvalid_o` becomes 0, and `ovf_o` and `unf_o` become 0.
- R2: Command code 1 (push) writes `wr_data_i` into the slot that becomes the new ST(0). Every older slot ST(k) becomes ST(k+1). `top_o` decreases by one modulo 8 (0 goes to 7), and `lvalid_o[0]` becomes 1.
- R3: Command code 2 (pop) retires ST(0). The old ST(1) becomes ST(0), `top_o` increases by one modulo 8, and `lvalid_o[7]` becomes 0.
- R4: Reads are combinational from the current top. `opa_o` shows ST(0). `opb_o` shows ST(`idx_i`) when `mem_sel_i` is 0, and shows `mem_opnd_i` when `mem_sel_i` is 1.
- R5: Command code 3 (operate) with `rev_i` = 0 writes `wr_data_i` into ST(0) and leaves ST(`idx_i`) unchanged.
- R6: Command code 3 with `rev_i` = 1 writes `wr_data_i` into ST(`idx_i`) and leaves ST(0) unchanged.
- R7: Command code 3 with `pop_i` = 1 resolves the destination with the top value from before the pop, writes the result there, and then pops, all at one clock edge. With `rev_i` = 1 and `idx_i` = 1, the result ends up in the new ST(0).
- R8: Command code 4 (exchange) swaps the contents of ST(0) and ST(`idx_i`) at one edge and leaves `top_o` unchanged.
- R9: Command code 5 (store) writes `wr_data_i` into ST(`idx_i`) and marks that slot valid. `top_o` is unchanged.
- R10: A push while `lvalid_o[7]` is 1 sets `ovf_o` and leaves `top_o` and all contents unchanged.
- R11: A pop, operate or exchange whose operand slot is empty sets `unf_o` and changes no stored state. An operate with `mem_sel_i` = 1 reads only ST(0).
- R12: `ovf_o` and `unf_o` stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Command: 0 idle, 1 push, 2 pop, 3 operate, 4 exchange, 5 store |
| idx_i | input | 3 | Offset i from the top for ST(i) |
| rev_i | input | 1 | Operate destination: 0 is ST(0), 1 is ST(i) |
| pop_i | input | 1 | Pop after an operate |
| mem_sel_i | input | 1 | Right operand comes from `mem_opnd_i` |
| wr_data_i | input | 80 | Push value, operate result or store value |
| mem_opnd_i | input | 80 | External right operand |
| opa_o | output | 80 | ST(0) |
| opb_o | output | 80 | ST(i) or the external operand |
| top_o | output | 3 | Current top pointer |
| lvalid_o | output | 8 | Valid tag of each logical slot ST(k) |
| ovf_o | output | 1 | Sticky overflow |
| unf_o | output | 1 | Sticky underflow |

## Verification
A wrong top pointer shows up at the ports immediately. It shifts the whole `lvalid_o` pattern, and `opa_o` and `opb_o` present words from the wrong slots right after the edge that corrupted it. A lost or stray tag bit changes `lvalid_o` on the next cycle. It also makes a later push or operand read raise a fault flag that should stay clear, or miss one that should be raised. Misrouted write ports show up only when the affected slot is read back through `opb_o`. For that reason, the bench sweeps `idx_i` over the slots that neighbour every write.

// File: rtl/fpr_pkg.sv
// Package: shared command encoding for the top-relative register stack.
// Assumes the command field is 3 bits wide; unused codes act as idle.
package fpr_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_PUSH  = 3'd1,
        CMD_POP   = 3'd2,
        CMD_ARITH = 3'd3,
        CMD_XCHG  = 3'd4,
        CMD_STORE = 3'd5
    } fpr_cmd_e;

endpackage

// File: rtl/fpr_top_ptr.sv
// Module: top-of-stack pointer register.
// Decrements on push and increments on pop, wrapping modulo 2**PTR_W.
// Assumes dec_i and inc_i are never both high in one cycle.
module fpr_top_ptr #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_i,
    input  logic             inc_i,
    output logic [PTR_W-1:0] top_o
);

    logic [PTR_W-1:0] top_q;

    // Update the pointer with wrap-around arithmetic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else if (dec_i) begin
            top_q <= top_q - PTR_W'(1);
        end else if (inc_i) begin
            top_q <= top_q + PTR_W'(1);
        end
    end

    assign top_o = top_q;

endmodule

// File: rtl/fpr_tag_file.sv
// Module: one valid tag per physical entry.
// Has one set port and one clear port; clear wins when both hit the same entry.
module fpr_tag_file #(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en_i,
    input  logic [PTR_W-1:0] set_idx_i,
    input  logic             clr_en_i,
    input  logic [PTR_W-1:0] clr_idx_i,
    output logic [DEPTH-1:0] tags_o
);

    logic [DEPTH-1:0] tag_q;

    // Per-entry tag update; the clear is applied after the set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (set_en_i && (set_idx_i == PTR_W'(e))) tag_q[e] <= 1'b1;
                if (clr_en_i && (clr_idx_i == PTR_W'(e))) tag_q[e] <= 1'b0;
            end
        end
    end

    assign tags_o = tag_q;

endmodule

// File: rtl/fpr_data_file.sv
// Module: physical word storage with two write ports and two read ports.
// Port B is applied after port A on a shared index. Reads are combinational.
module fpr_data_file #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 80,
    parameter int PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wa_en_i,
    input  logic [PTR_W-1:0]  wa_idx_i,
    input  logic [WORD_W-1:0] wa_data_i,
    input  logic              wb_en_i,
    input  logic [PTR_W-1:0]  wb_idx_i,
    input  logic [WORD_W-1:0] wb_data_i,
    input  logic [PTR_W-1:0]  rd0_idx_i,
    input  logic [PTR_W-1:0]  rd1_idx_i,
    output logic [WORD_W-1:0] rd0_data_o,
    output logic [WORD_W-1:0] rd1_data_o
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    // Write both ports into the entry array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (wa_en_i && (wa_idx_i == PTR_W'(e))) mem_q[e] <= wa_data_i;
                if (wb_en_i && (wb_idx_i == PTR_W'(e))) mem_q[e] <= wb_data_i;
            end
        end
    end

    // Combinational read ports.
    always_comb begin
        rd0_data_o = mem_q[rd0_idx_i];
        rd1_data_o = mem_q[rd1_idx_i];
    end

endmodule

// File: rtl/fpr_fault_unit.sv
// Module: detects stack overflow and underflow and keeps them as sticky flags.
// go_o is low when the current command faults, which blocks every state change.
module fpr_fault_unit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cmd_i,
    input  logic       mem_sel_i,
    input  logic       v_top_i,
    input  logic       v_idx_i,
    input  logic       v_push_i,
    output logic       go_o,
    output logic       ovf_o,
    output logic       unf_o
);

    import fpr_pkg::*;

    logic ovf_evt, unf_evt, ovf_q, unf_q;

    // Classify the current command against the tags it needs.
    always_comb begin
        ovf_evt = 1'b0;
        unf_evt = 1'b0;
        case (fpr_cmd_e'(cmd_i))
            CMD_PUSH:  ovf_evt = v_push_i;
            CMD_POP:   unf_evt = !v_top_i;
            CMD_ARITH: unf_evt = !v_top_i || (!mem_sel_i && !v_idx_i);
            CMD_XCHG:  unf_evt = !v_top_i || !v_idx_i;
            default:   ;
        endcase
        go_o = !ovf_evt && !unf_evt;
    end

    // Sticky fault flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (ovf_evt) ovf_q <= 1'b1;
            if (unf_evt) unf_q <= 1'b1;
        end
    end

    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

endmodule

// File: rtl/fpr_stack.sv
// Module: top-relative register stack for a floating-point unit.
// Maps logical slot ST(i) onto physical entry (top + i) mod DEPTH and
// steers push, pop, operate, exchange and store commands onto the storage.
// Assumes DEPTH is a power of two, so pointer arithmetic wraps for free.
module fpr_stack #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 80,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [PTR_W-1:0]  idx_i,
    input  logic              rev_i,
    input  logic              pop_i,
    input  logic              mem_sel_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [WORD_W-1:0] mem_opnd_i,
    output logic [WORD_W-1:0] opa_o,
    output logic [WORD_W-1:0] opb_o,
    output logic [PTR_W-1:0]  top_o,
    output logic [DEPTH-1:0]  lvalid_o,
    output logic              ovf_o,
    output logic              unf_o
);

    import fpr_pkg::*;

    logic [PTR_W-1:0]  top_q, ph_top, ph_idx, ph_push, ph_dest;
    logic [DEPTH-1:0]  tags;
    logic [WORD_W-1:0] rd_top, rd_idx;
    logic              go, ptr_dec, ptr_inc;
    logic              wa_en, wb_en, set_en, clr_en;
    logic [PTR_W-1:0]  wa_idx, wb_idx, set_idx, clr_idx;
    logic [WORD_W-1:0] wa_data, wb_data;

    // Physical indices of the slots a command can touch.
    always_comb begin
        ph_top  = top_q;
        ph_idx  = top_q + idx_i;
        ph_push = top_q - PTR_W'(1);
        ph_dest = rev_i ? ph_idx : ph_top;
    end

    fpr_top_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .dec_i (ptr_dec),
        .inc_i (ptr_inc),
        .top_o (top_q)
    );

    fpr_tag_file #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en_i  (set_en),
        .set_idx_i (set_idx),
        .clr_en_i  (clr_en),
        .clr_idx_i (clr_idx),
        .tags_o    (tags)
    );

    fpr_data_file #(.DEPTH(DEPTH), .WORD_W(WORD_W), .PTR_W(PTR_W)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .wa_en_i    (wa_en),
        .wa_idx_i   (wa_idx),
        .wa_data_i  (wa_data),
        .wb_en_i    (wb_en),
        .wb_idx_i   (wb_idx),
        .wb_data_i  (wb_data),
        .rd0_idx_i  (ph_top),
        .rd1_idx_i  (ph_idx),
        .rd0_data_o (rd_top),
        .rd1_data_o (rd_idx)
    );

    fpr_fault_unit u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd_i),
        .mem_sel_i (mem_sel_i),
        .v_top_i   (tags[ph_top]),
        .v_idx_i   (tags[ph_idx]),
        .v_push_i  (tags[ph_push]),
        .go_o      (go),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o)
    );

    // Command steering onto write ports, tag ports and the pointer.
    always_comb begin
        wa_en   = 1'b0;
        wa_idx  = ph_top;
        wa_data = wr_data_i;
        wb_en   = 1'b0;
        wb_idx  = ph_idx;
        wb_data = rd_top;
        set_en  = 1'b0;
        set_idx = ph_top;
        clr_en  = 1'b0;
        clr_idx = ph_top;
        ptr_dec = 1'b0;
        ptr_inc = 1'b0;
        case (fpr_cmd_e'(cmd_i))
            CMD_PUSH: begin
                wa_en   = go;
                wa_idx  = ph_push;
                set_en  = go;
                set_idx = ph_push;
                ptr_dec = go;
            end
            CMD_POP: begin
                clr_en  = go;
                ptr_inc = go;
            end
            CMD_ARITH: begin
                wa_en   = go;
                wa_idx  = ph_dest;
                set_en  = go;
                set_idx = ph_dest;
                clr_en  = go && pop_i;
                ptr_inc = go && pop_i;
            end
            CMD_XCHG: begin
                wa_en   = go;
                wa_data = rd_idx;
                wb_en   = go;
            end
            CMD_STORE: begin
                wa_en   = go;
                wa_idx  = ph_idx;
                set_en  = go;
                set_idx = ph_idx;
            end
            default: ;
        endcase
    end

    // Rotate the physical tags into logical slot order.
    for (genvar g = 0; g < DEPTH; g++) begin : g_lvalid
        assign lvalid_o[g] = tags[PTR_W'(top_q + PTR_W'(g))];
    end

    // Operand outputs.
    always_comb begin
        opa_o = rd_top;
        opb_o = mem_sel_i ? mem_opnd_i : rd_idx;
    end

    assign top_o = top_q;

endmodule

// File: rtl/fpr_stack_chk.sv
// Module: property checker for fpr_stack, attached by bind.
// Observes only ports of the stack.
module fpr_stack_chk #(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cmd_i,
    input logic [PTR_W-1:0] top_o,
    input logic [DEPTH-1:0] lvalid_o,
    input logic             ovf_o,
    input logic             unf_o
);

    import fpr_pkg::*;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (top_o == '0) && (lvalid_o == '0) && !ovf_o && !unf_o); // R1

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PUSH) && !lvalid_o[DEPTH-1] |=>
            (top_o == PTR_W'($past(top_o) - PTR_W'(1))) && lvalid_o[0]); // R2

    AST_POP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_POP) && lvalid_o[0] |=>
            (top_o == PTR_W'($past(top_o) + PTR_W'(1))) && !lvalid_o[DEPTH-1]); // R3

    AST_NO_OVERFLOW_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PUSH) && lvalid_o[DEPTH-1] |=> ovf_o && $stable(top_o)); // R10

    AST_UNDERFLOW_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_POP) && !lvalid_o[0] |=> unf_o && $stable(top_o)); // R11

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R12

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o); // R12

endmodule

bind fpr_stack fpr_stack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd_i),
    .top_o    (top_o),
    .lvalid_o (lvalid_o),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o)
);

// File: tb/fpr_stack_bench.sv
// Directed bench for fpr_stack: one task per scenario, each checking itself.
module fpr_stack_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 80;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cmd = 3'd0;
    logic [2:0]        idx = 3'd0;
    logic              rev = 1'b0;
    logic              popf = 1'b0;
    logic              msel = 1'b0;
    logic [WORD_W-1:0] wdata = '0;
    logic [WORD_W-1:0] mopnd = '0;
    logic [WORD_W-1:0] opa, opb;
    logic [2:0]        top;
    logic [7:0]        lvalid;
    logic              ovf, unf;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    fpr_stack u_fpr_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .idx_i      (idx),
        .rev_i      (rev),
        .pop_i      (popf),
        .mem_sel_i  (msel),
        .wr_data_i  (wdata),
        .mem_opnd_i (mopnd),
        .opa_o      (opa),
        .opb_o      (opb),
        .top_o      (top),
        .lvalid_o   (lvalid),
        .ovf_o      (ovf),
        .unf_o      (unf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [WORD_W-1:0] val(input int k);
        return {16'h3FFF, 32'hC0DE0000, 32'(k)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what,
                          input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        chk(act === exp, req, what, act, exp);
    endtask

    // Apply one command for one clock edge, then return to idle.
    task automatic issue(input logic [2:0] c, input logic [2:0] i, input logic r,
                         input logic p, input logic m, input logic [WORD_W-1:0] d);
        cmd = c; idx = i; rev = r; popf = p; msel = m; wdata = d;
        @(posedge clk);
        #1;
        cmd = 3'd0; rev = 1'b0; popf = 1'b0; msel = 1'b0;
    endtask

    // Select a read slot and let the combinational outputs settle.
    task automatic peek(input logic [2:0] i, input logic m);
        idx = i; msel = m;
        #1;
    endtask

    task automatic do_reset();
        cmd = 3'd0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk_eq("R1", "top", WORD_W'(top), 0);
        chk_eq("R1", "lvalid", WORD_W'(lvalid), 0);
        chk_eq("R1", "flags", WORD_W'({ovf, unf}), 0);
    endtask

    task automatic t_push_pop();
        do_reset();
        issue(3'd1, 0, 0, 0, 0, val(1));
        issue(3'd1, 0, 0, 0, 0, val(2));
        issue(3'd1, 0, 0, 0, 0, val(3));
        chk_eq("R2", "top after 3 pushes", WORD_W'(top), 5);
        chk_eq("R2", "lvalid after 3 pushes", WORD_W'(lvalid), 8'b0000_0111);
        peek(3'd2, 1'b0);
        chk_eq("R2", "ST0 newest", opa, val(3));
        chk_eq("R4", "ST2 oldest", opb, val(1));
        peek(3'd1, 1'b0);
        chk_eq("R4", "ST1", opb, val(2));
        mopnd = val(77);
        peek(3'd1, 1'b1);
        chk_eq("R4", "external operand", opb, val(77));
        issue(3'd2, 0, 0, 0, 0, '0);
        chk_eq("R3", "top after pop", WORD_W'(top), 6);
        chk_eq("R3", "lvalid after pop", WORD_W'(lvalid), 8'b0000_0011);
        peek(3'd1, 1'b0);
        chk_eq("R3", "new ST0", opa, val(2));
        chk_eq("R3", "new ST1", opb, val(1));
    endtask

    task automatic t_arith();
        do_reset();
        issue(3'd1, 0, 0, 0, 0, val(10));
        issue(3'd1, 0, 0, 0, 0, val(11));
        issue(3'd3, 3'd5, 0, 0, 1, val(12));
        chk_eq("R11", "memory form reads only ST0", WORD_W'(unf), 0);
        chk_eq("R5", "memory form result in ST0", opa, val(12));
        issue(3'd3, 3'd1, 0, 0, 0, val(20));
        peek(3'd1, 1'b0);
        chk_eq("R5", "normal dest ST0", opa, val(20));
        chk_eq("R5", "ST1 untouched", opb, val(10));
        issue(3'd3, 3'd1, 1, 0, 0, val(21));
        peek(3'd1, 1'b0);
        chk_eq("R6", "reversed dest ST1", opb, val(21));
        chk_eq("R6", "ST0 untouched", opa, val(20));
        issue(3'd3, 3'd1, 1, 1, 0, val(22));
        chk_eq("R7", "top after op-pop", WORD_W'(top), 7);
        chk_eq("R7", "result in new ST0", opa, val(22));
        chk_eq("R7", "lvalid after op-pop", WORD_W'(lvalid), 8'b0000_0001);
        chk_eq("R7", "no fault", WORD_W'({ovf, unf}), 0);
    endtask

    task automatic t_xchg();
        do_reset();
        for (int k = 1; k <= 3; k++) issue(3'd1, 0, 0, 0, 0, val(30 + k));
        issue(3'd4, 3'd2, 0, 0, 0, '0);
        peek(3'd2, 1'b0);
        chk_eq("R8", "ST0 after swap", opa, val(31));
        chk_eq("R8", "ST2 after swap", opb, val(33));
        peek(3'd1, 1'b0);
        chk_eq("R8", "ST1 untouched", opb, val(32));
        chk_eq("R8", "top unchanged", WORD_W'(top), 5);
    endtask

    task automatic t_store();
        do_reset();
        issue(3'd1, 0, 0, 0, 0, val(40));
        issue(3'd5, 3'd3, 0, 0, 0, val(41));
        chk_eq("R9", "lvalid after store", WORD_W'(lvalid), 8'b0000_1001);
        chk_eq("R9", "top unchanged", WORD_W'(top), 7);
        peek(3'd3, 1'b0);
        chk_eq("R9", "ST3 value", opb, val(41));
        chk_eq("R9", "ST0 untouched", opa, val(40));
    endtask

    task automatic t_overflow();
        do_reset();
        for (int k = 0; k < 8; k++) issue(3'd1, 0, 0, 0, 0, val(50 + k));
        chk_eq("R10", "full stack", WORD_W'(lvalid), 8'hFF);
        chk_eq("R10", "no overflow yet", WORD_W'(ovf), 0);
        issue(3'd1, 0, 0, 0, 0, val(99));
        chk_eq("R10", "overflow raised", WORD_W'(ovf), 1);
        chk_eq("R10", "top unchanged", WORD_W'(top), 0);
        peek(3'd7, 1'b0);
        chk_eq("R10", "ST0 unchanged", opa, val(57));
        chk_eq("R10", "ST7 unchanged", opb, val(50));
        issue(3'd2, 0, 0, 0, 0, '0);
        issue(3'd0, 0, 0, 0, 0, '0);
        chk_eq("R12", "overflow sticky", WORD_W'(ovf), 1);
        chk_eq("R12", "no underflow", WORD_W'(unf), 0);
    endtask

    task automatic t_underflow();
        do_reset();
        issue(3'd2, 0, 0, 0, 0, '0);
        chk_eq("R11", "pop of empty raises", WORD_W'(unf), 1);
        chk_eq("R11", "top unchanged on empty pop", WORD_W'(top), 0);
        do_reset();
        chk_eq("R12", "reset clears underflow", WORD_W'(unf), 0);
        issue(3'd1, 0, 0, 0, 0, val(60));
        issue(3'd3, 3'd1, 0, 0, 0, val(61));
        chk_eq("R11", "operate on empty ST1", WORD_W'(unf), 1);
        chk_eq("R11", "ST0 kept", opa, val(60));
        chk_eq("R11", "lvalid kept", WORD_W'(lvalid), 8'b0000_0001);
        issue(3'd4, 3'd4, 0, 0, 0, '0);
        chk_eq("R11", "exchange with empty blocked", opa, val(60));
        issue(3'd1, 0, 0, 0, 0, val(62));
        chk_eq("R12", "underflow sticky", WORD_W'(unf), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_push_pop();
        t_arith();
        t_xchg();
        t_store();
        t_overflow();
        t_underflow();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule